// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block is a synthesizable model of a serial EEPROM target on a three-wire bus: chip select, serial clock and serial data in, plus a data-out line with an output enable. The three bus inputs are brought into a fast system clock domain through synchronisers. Serial-clock edges are detected there. An instruction is a start bit, a two-bit opcode and an address field. The block decodes these and then reads from, writes to or erases an internal storage array. Storage starts out erased, with every bit at 1.

An organisation input selects how the array is seen. With the input low, the array is a set of 8-bit bytes. With it high, the array is a set of 16-bit words and the address is one bit shorter. Every operation that modifies storage is refused until the host unlocks programming, and programming stays unlocked until the host locks it again.

A modifying operation starts a self-timed programming cycle, which a counter in system clock cycles models. While that cycle runs, the target ignores the bus. When chip select is raised, the data-out line reports whether the target is still busy.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset every storage bit reads 1, programming is locked, and the output enable is low.
- R2: An instruction is a start bit of 1, then a 2-bit opcode, then the address field, all MSB first. The opcodes are 10 for read, 01 for write, 11 for erase and 00 for the extended group. In the extended group, the top two address bits select the operation: 11 unlock, 00 lock, 10 erase all, 01 write all. The remaining address bits are ignored.
- R3: A read drives a single 0 dummy bit after the last address bit, then the data MSB first. Each output bit changes after a rising serial-clock edge.
- R4: While chip select stays high, a read continues with the next address, with no dummy bit between words. The address wraps from the last location to 0.
- R5: With org_i low, words are 8 bits and the address is ADDR_W8 bits. With org_i high, words are 16 bits and the address is ADDR_W8-1 bits. Word w then holds byte 2w in bits 15:8 and byte 2w+1 in bits 7:0.
- R6: Write, erase, erase-all and write-all leave storage unchanged unless an unlock has come after reset or after the most recent lock. Read works in both states.
- R7: Erase sets every bit of the addressed word to 1 and leaves other words unchanged.
- R8: Erase-all sets every bit of the array to 1. Write-all stores the supplied word in every location.
- R9: An accepted modifying instruction starts a programming cycle of WC_CYCLES system clocks. While chip select is high after that, data-out reads 0 during the cycle and 1 after it. The 1 holds until chip select falls or a new start bit is decoded.
- R10: Serial-clock edges that arrive while a programming cycle runs are ignored, so an instruction sent in that window has no effect.
- R11: The output enable is low whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in, sampled on rising serial-clock edges |
| org_i | input | 1 | Organisation select: 1 for 16-bit words, 0 for 8-bit bytes |
| do_o | output | 1 | Serial data out: read data or ready/busy level |
| do_oe_o | output | 1 | Output enable for do_o; low means high impedance |

## Verification
If the bit counter is off by one, the opcode is decoded from the wrong bits. The first read after the fault then returns shifted data, or a missing or doubled dummy bit, within one instruction. A fault in the lock flag or in the busy counter shows up at data-out in the next status poll. It also shows up in the next read of a location that a refused or ignored instruction must not have touched. A wrong byte-to-word mapping only appears when the same storage is read back under the other organisation. For that reason, every byte is written in one organisation and checked again in the other.

// File: rtl/seep_pkg.sv
package seep_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } opcode_e;

    typedef enum logic [1:0] {
        EX_LOCK   = 2'b00,
        EX_FILLW  = 2'b01,
        EX_CLRALL = 2'b10,
        EX_UNLOCK = 2'b11
    } ext_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_DATA,
        ST_READ,
        ST_SKIP
    } state_e;

    typedef struct packed {
        logic              go;
        logic              all;
        logic [WORD_W-1:0] data;
    } prog_req_t;

    function automatic int addr_len(input logic wide, input int aw8);
        return wide ? aw8 - 1 : aw8;
    endfunction

endpackage

// File: rtl/seep_sync.sv
module seep_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= {pipe[STAGES-2:0], async_i[g]};
        end
        assign level_o[g] = pipe[STAGES-1];
    end

endmodule

// File: rtl/seep_array.sv
module seep_array
    import seep_pkg::*;
#(
    parameter int AW8 = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wide,
    input  logic [AW8-1:0]    rd_addr,
    input  prog_req_t         prog,
    input  logic [AW8-1:0]    prog_addr,
    output logic [WORD_W-1:0] rd_word
);

    localparam int WORDS = 2 ** (AW8 - 1);
    localparam int WI_W  = AW8 - 1;

    logic [WORD_W-1:0] mem [WORDS];
    logic [WI_W-1:0]   wr_idx;
    logic [WORD_W-1:0] wr_val, wr_mask, rw;

    always_comb begin
        if (wide) begin
            wr_idx  = prog_addr[WI_W-1:0];
            wr_val  = prog.data;
            wr_mask = '1;
        end else begin
            wr_idx  = prog_addr[AW8-1:1];
            wr_val  = {prog.data[BYTE_W-1:0], prog.data[BYTE_W-1:0]};
            if (prog.all)         wr_mask = '1;
            else if (prog_addr[0]) wr_mask = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
            else                   wr_mask = {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}};
        end
    end

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '1;
            else if (prog.go && (prog.all || wr_idx == WI_W'(i)))
                mem[i] <= (mem[i] & ~wr_mask) | (wr_val & wr_mask);
        end
    end

    always_comb begin
        rw = mem[wide ? rd_addr[WI_W-1:0] : rd_addr[AW8-1:1]];
        if (wide)            rd_word = rw;
        else if (rd_addr[0]) rd_word = {{BYTE_W{1'b0}}, rw[BYTE_W-1:0]};
        else                 rd_word = {{BYTE_W{1'b0}}, rw[WORD_W-1:BYTE_W]};
    end

    // R8: a fill of the whole array reaches the last word
    p_fill_all_r8: assert property (@(posedge clk) disable iff (rst)
        (prog.go && prog.all) |=> mem[WORDS-1] ==
            ($past(wide) ? $past(prog.data)
                         : {$past(prog.data[BYTE_W-1:0]), $past(prog.data[BYTE_W-1:0])}));

endmodule

// File: rtl/seep_ctrl.sv
module seep_ctrl
    import seep_pkg::*;
#(
    parameter int AW8       = 7,
    parameter int WC_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              sk,
    input  logic              di,
    input  logic              org,
    input  logic [WORD_W-1:0] rd_word,
    output logic [AW8-1:0]    rd_addr,
    output prog_req_t         prog,
    output logic [AW8-1:0]    prog_addr,
    output logic              dout,
    output logic              doe
);

    localparam int HW = AW8 + 2;
    localparam int CW = $clog2(WORD_W + HW + 1);
    localparam int TW = $clog2(WC_CYCLES + 1);

    state_e            state;
    logic [HW-2:0]     head;
    logic [WORD_W-2:0] dsr;
    logic [CW-1:0]     cnt;
    logic [AW8-1:0]    addr;
    logic              wen, status, rd_mode, fill_all, dbit, sk_q, cs_q;
    logic [TW-1:0]     busy_cnt;

    logic              busy, sk_rise, cs_fall;
    logic [HW-1:0]     head_n;
    opcode_e           op;
    ext_e              ext;
    logic [AW8-1:0]    field, next_addr;
    logic [CW-1:0]     hlast, wlast;
    logic [WORD_W-1:0] data_n;
    logic [3:0]        bit_idx;

    always_comb begin
        busy    = busy_cnt != '0;
        sk_rise = sk & ~sk_q;
        cs_fall = cs_q & ~cs;
        head_n  = {head, di};
        data_n  = {dsr, di};
        hlast   = CW'(addr_len(org, AW8) + 1);
        wlast   = org ? CW'(WORD_W - 1) : CW'(BYTE_W - 1);
        bit_idx = 4'(wlast - cnt);
        if (org) begin
            op        = opcode_e'(head_n[AW8:AW8-1]);
            ext       = ext_e'(head_n[AW8-2:AW8-3]);
            field     = {1'b0, head_n[AW8-2:0]};
            next_addr = {1'b0, addr[AW8-2:0] + 1'b1};
        end else begin
            op        = opcode_e'(head_n[AW8+1:AW8]);
            ext       = ext_e'(head_n[AW8-1:AW8-2]);
            field     = head_n[AW8-1:0];
            next_addr = addr + 1'b1;
        end
        rd_addr = addr;
        doe     = cs && (status || rd_mode);
        dout    = status ? !busy : dbit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;  head <= '0;     dsr <= '0;      cnt <= '0;
            addr <= '0;        wen <= 1'b0;    status <= 1'b0; rd_mode <= 1'b0;
            fill_all <= 1'b0;  dbit <= 1'b0;   busy_cnt <= '0; prog <= '0;
            prog_addr <= '0;   sk_q <= 1'b0;   cs_q <= 1'b0;
        end else begin
            sk_q    <= sk;
            cs_q    <= cs;
            prog.go <= 1'b0;
            if (busy) busy_cnt <= busy_cnt - 1'b1;
            if (!cs) begin
                state   <= ST_IDLE;
                rd_mode <= 1'b0;
                if (cs_fall && !busy) status <= 1'b0;
            end else if (sk_rise && !busy) begin
                unique case (state)
                    ST_IDLE: if (di) begin
                        state  <= ST_HEAD;
                        cnt    <= '0;
                        status <= 1'b0;
                    end
                    ST_HEAD: begin
                        head <= head_n[HW-2:0];
                        cnt  <= cnt + 1'b1;
                        if (cnt == hlast) begin
                            cnt <= '0;
                            unique case (op)
                                OP_READ: begin
                                    addr <= field; state <= ST_READ;
                                    rd_mode <= 1'b1; dbit <= 1'b0;
                                end
                                OP_WRITE: begin
                                    addr <= field; fill_all <= 1'b0; state <= ST_DATA;
                                end
                                OP_ERASE: begin
                                    state <= ST_SKIP;
                                    if (wen) begin
                                        prog      <= '{1'b1, 1'b0, {WORD_W{1'b1}}};
                                        prog_addr <= field;
                                        busy_cnt  <= TW'(WC_CYCLES);
                                        status    <= 1'b1;
                                    end
                                end
                                default: begin
                                    unique case (ext)
                                        EX_UNLOCK: begin wen <= 1'b1; state <= ST_SKIP; end
                                        EX_LOCK:   begin wen <= 1'b0; state <= ST_SKIP; end
                                        EX_CLRALL: begin
                                            state <= ST_SKIP;
                                            if (wen) begin
                                                prog     <= '{1'b1, 1'b1, {WORD_W{1'b1}}};
                                                busy_cnt <= TW'(WC_CYCLES);
                                                status   <= 1'b1;
                                            end
                                        end
                                        default: begin fill_all <= 1'b1; state <= ST_DATA; end
                                    endcase
                                end
                            endcase
                        end
                    end
                    ST_DATA: begin
                        dsr <= data_n[WORD_W-2:0];
                        cnt <= cnt + 1'b1;
                        if (cnt == wlast) begin
                            state <= ST_SKIP;
                            if (wen) begin
                                prog      <= '{1'b1, fill_all, data_n};
                                prog_addr <= addr;
                                busy_cnt  <= TW'(WC_CYCLES);
                                status    <= 1'b1;
                            end
                        end
                    end
                    ST_READ: begin
                        dbit <= rd_word[bit_idx];
                        if (cnt == wlast) begin
                            cnt  <= '0;
                            addr <= next_addr;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_SKIP: ;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R6: storage is only modified while programming is unlocked
    p_lock_r6: assert property (@(posedge clk) disable iff (rst)
        prog.go |-> wen);

    // R9: every programming request opens a full busy window
    p_prog_busy_r9: assert property (@(posedge clk) disable iff (rst)
        prog.go |-> busy_cnt == TW'(WC_CYCLES));

    // R10: serial clock edges during the busy window leave the decoder untouched
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && sk_rise && cs) |=> (state == $past(state) && cnt == $past(cnt)));

    // R3: a read begins with a 0 dummy bit
    p_dummy_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_mode) |-> !dbit);

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
    import seep_pkg::*;
#(
    parameter int ADDR_W8   = 7,
    parameter int WC_CYCLES = 64,
    parameter int SYNC_STG  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    input  logic org_i,
    output logic do_o,
    output logic do_oe_o
);

    logic [2:0]        lvl;
    logic [WORD_W-1:0] rd_word;
    logic [ADDR_W8-1:0] rd_addr, prog_addr;
    prog_req_t         prog;

    seep_sync #(.N(3), .STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({di_i, sk_i, cs_i}),
        .level_o (lvl)
    );

    seep_ctrl #(.AW8(ADDR_W8), .WC_CYCLES(WC_CYCLES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cs        (lvl[0]),
        .sk        (lvl[1]),
        .di        (lvl[2]),
        .org       (org_i),
        .rd_word   (rd_word),
        .rd_addr   (rd_addr),
        .prog      (prog),
        .prog_addr (prog_addr),
        .dout      (do_o),
        .doe       (do_oe_o)
    );

    seep_array #(.AW8(ADDR_W8)) u_array (
        .clk       (clk),
        .rst       (rst),
        .wide      (org_i),
        .rd_addr   (rd_addr),
        .prog      (prog),
        .prog_addr (prog_addr),
        .rd_word   (rd_word)
    );

endmodule

// File: tb/test_serial_eeprom_slave.sv
module test_serial_eeprom_slave;

    localparam int AW8 = 7;
    localparam int WC  = 320;
    localparam int H   = 4;
    localparam int NB  = 2 ** AW8;

    logic clk = 1'b0, rst = 1'b1, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b0;
    logic do_o, do_oe;
    int   checks = 0, fails = 0;
    bit   done = 1'b0;
    logic [7:0] model [NB];

    always #2.5 clk = ~clk;

    serial_eeprom_slave #(.ADDR_W8(AW8), .WC_CYCLES(WC)) i_serial_eeprom_slave (
        .clk(clk), .rst(rst), .cs_i(cs), .sk_i(sk), .di_i(di), .org_i(org),
        .do_o(do_o), .do_oe_o(do_oe)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b);
        di = b; tick(H); sk = 1'b1; tick(H); sk = 1'b0;
    endtask

    task automatic send(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
    endtask

    function automatic int alen();
        return org ? AW8 - 1 : AW8;
    endfunction

    function automatic int wlen();
        return org ? 16 : 8;
    endfunction

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 29 + 7) & 255);
    endfunction

    function automatic logic [15:0] expect_word(input int i);
        return org ? {model[2*i], model[2*i+1]} : {8'h00, model[i]};
    endfunction

    task automatic sel();
        cs = 1'b1; tick(4);
    endtask

    task automatic desel();
        sk = 1'b0; di = 1'b0; cs = 1'b0; tick(6);
    endtask

    task automatic header(input logic [1:0] op, input int a);
        sel(); clk_bit(1'b1); send(16'(op), 2); send(16'(a), alen());
    endtask

    task automatic run_op(input logic [1:0] op, input int a, input logic [15:0] d, input bit with_data);
        header(op, a);
        if (with_data) send(d, wlen());
        desel();
        tick(WC + 20);
    endtask

    task automatic read_run(input int start, input int n, input string req);
        int words;
        logic [15:0] got;
        words = org ? NB / 2 : NB;
        header(2'b10, start);
        di = 1'b0; tick(H);
        check({req, " R3 dummy"}, {14'b0, do_oe, do_o}, 16'h0002);
        sk = 1'b1; tick(H); sk = 1'b0;
        for (int k = 0; k < n; k++) begin
            got = '0;
            for (int b = 0; b < wlen(); b++) begin
                tick(H);
                got = {got[14:0], do_o};
                sk = 1'b1; tick(H); sk = 1'b0;
            end
            check(req, got, expect_word((start + k) % words));
        end
        desel();
    endtask

    initial begin
        for (int i = 0; i < NB; i++) model[i] = 8'hFF;
        tick(10); rst = 1'b0; tick(4);
        // R1 R11: released output and erased storage after reset
        check("R1 R11 oe after reset", {15'b0, do_oe}, 16'h0);
        org = 1'b0;
        read_run(0, 1, "R1 erased");

        // R6: write refused before unlock
        run_op(2'b01, 5, 16'h003C, 1'b1);
        read_run(5, 1, "R6 locked write");

        // R2: unlock, then every byte written in 8-bit organisation
        run_op(2'b00, 3 << (alen() - 2), 16'h0, 1'b0);
        for (int a = 0; a < NB; a++) begin
            run_op(2'b01, a, {8'h00, pat(a)}, 1'b1);
            model[a] = pat(a);
        end
        read_run(0, NB + 1, "R2 R4 byte sweep with wrap");

        // R5: same storage seen as 16-bit words
        org = 1'b1;
        read_run(0, NB / 2, "R5 word view");
        read_run(NB / 2 - 2, 4, "R4 word wrap");

        // R9 R10: status polling and an instruction sent while busy
        org = 1'b0;
        header(2'b01, 10); send(16'h005A, 8); desel();
        model[10] = 8'h5A;
        sel(); tick(2);
        check("R9 busy level", {14'b0, do_oe, do_o}, 16'h0002);
        clk_bit(1'b1); send(16'h1, 2); send(16'd11, 7); send(16'h0, 8);
        check("R9 still busy", {14'b0, do_oe, do_o}, 16'h0002);
        tick(WC);
        check("R9 ready level", {14'b0, do_oe, do_o}, 16'h0003);
        tick(40);
        check("R9 ready held", {14'b0, do_oe, do_o}, 16'h0003);
        desel();
        check("R11 released on deselect", {15'b0, do_oe}, 16'h0);
        read_run(10, 2, "R10 ignored while busy");

        // R7: erase one word in 16-bit organisation
        org = 1'b1;
        run_op(2'b11, 7, 16'h0, 1'b0);
        model[14] = 8'hFF; model[15] = 8'hFF;
        read_run(6, 3, "R7 erase word");

        // R8: write-all then erase-all
        run_op(2'b00, 1 << (alen() - 2), 16'hA55A, 1'b1);
        for (int i = 0; i < NB; i++) model[i] = (i % 2 == 0) ? 8'hA5 : 8'h5A;
        read_run(0, NB / 2, "R8 write-all");
        org = 1'b0;
        run_op(2'b00, 2 << (alen() - 2), 16'h0, 1'b0);
        for (int i = 0; i < NB; i++) model[i] = 8'hFF;
        read_run(0, 8, "R8 erase-all");

        // R6: lock again; write-all and write refused, read still works
        run_op(2'b00, 0, 16'h0, 1'b0);
        run_op(2'b00, 1 << (alen() - 2), 16'h0012, 1'b1);
        run_op(2'b01, 3, 16'h0000, 1'b1);
        read_run(0, 4, "R6 after lock");
        sel(); tick(4);
        check("R6 R9 no status after refused op", {15'b0, do_oe}, 16'h0);
        desel();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule